// File: doc/BRIEF.md
# Serial LED status scanner

This block turns a repeater's status flags into a periodic serial picture for a row of external shift-register LED drivers. At a fixed frame interval it freezes the current status into a snapshot and shifts 16 bit slots out on three parallel data lines. A gated shift clock gives exactly one rising edge per slot. Between frames the shift clock stays low and the data lines rest at the dark level. The utilization and collision bars arrive as ready-made 8-segment thermometer codes, where bit k set means segment k is lit. The block only places them in the frame.

After every reset the block runs a lamp test before it shows live status. Every LED is lit, then dark, then lit, then dark, and each phase lasts a whole number of frames. Only then does live status appear. All timing comes from the single reference clock. The shift clock runs at one tenth of it, and the frame spacing and lamp-test phases are counted in reference cycles and in frames. With a 25 MHz reference and the default parameters, the shift clock period is 400 ns, frames are about 52.4 ms apart, the lit and dark blink phases are 16 frames long and the closing dark phase is 8 frames long.

The status and LED pins are plain level signals. Nothing pushes back on the block, so there is no handshake at either edge.

Top module: `led_status_scanner`

## Requirements
- R1: Each frame has exactly 16 rising edges of `led_sclk_o`. Between frames `led_sclk_o` is held low and no edge occurs.
- R2: Within a frame the shift clock period is `SCLK_DIV` reference cycles. The clock is low for the first half of each slot and high for the second half. A data line changes only at the start of a slot, while the clock is low, and stays steady from the rising edge until that slot ends.
- R3: A frame starts every `FRAME_CYC` reference cycles, and each frame ends before the next frame tick.
- R4: Lane 0 carries these slots: d0–d4 are the partition flags of ports 0–4, d5–d9 are the jabber flags of ports 0–4, d10 is global partition, d11 is RAM fail, d12 is 10M global collision, d13 is 100M global collision, and d14–d15 are always dark. Slot d0 is shifted first.
- R5: Lane 1 carries these slots: d0–d4 are the activity flags of ports 0–4, d5–d7 are always dark, and d8–d15 are 10M utilization segments 0–7.
- R6: Lane 2 carries these slots: d0–d7 are 100M utilization segments 0–7, and d8–d15 form a collision bar. Segment k of that bar is lit when segment k of either the 10M or the 100M collision bar is lit.
- R7: The data lines are active low. A lit slot drives 0 and a dark slot drives 1. Outside a frame every data line is 1.
- R8: The status inputs are sampled once, at frame start. A change to the inputs during a frame does not appear until the next frame.
- R9: After reset, frames are fully lit for `BLINK_FRAMES` frames, fully dark for `BLINK_FRAMES`, fully lit for `BLINK_FRAMES`, and fully dark for `DARK_FRAMES`. Live status follows.
- R10: `rst_n` is an asynchronous active-low reset. While it is asserted, `led_sclk_o` is 0 and every data line is 1. When it is released, the frame timer restarts and so does the lamp test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (25 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_part_i | input | 5 | Per-port partition flags |
| port_jab_i | input | 5 | Per-port jabber flags |
| port_act_i | input | 5 | Per-port activity flags |
| glob_part_i | input | 1 | Global partition flag |
| ram_fail_i | input | 1 | Buffer RAM test failure flag |
| glob_col10_i | input | 1 | 10M global collision flag |
| glob_col100_i | input | 1 | 100M global collision flag |
| util10_bar_i | input | 8 | 10M utilization thermometer code |
| util100_bar_i | input | 8 | 100M utilization thermometer code |
| coll10_bar_i | input | 8 | 10M collision thermometer code |
| coll100_bar_i | input | 8 | 100M collision thermometer code |
| led_sclk_o | output | 1 | Gated shift clock |
| led_data_o | output | 3 | Serial data lanes, active low |

## Verification
The bound checker checks on every cycle that a frame contains sixteen shift-clock edges and that consecutive edges are one divider period apart. It also checks that the data lines never move while the shift clock is high and that a frame tick never arrives while a frame is still shifting.

Some behaviour can only be shown by the bench's scenarios. These are the slot map of each lane, the active-low levels, the merged collision bar and the frame-to-frame spacing. They also include the lamp-test sequence with its phase lengths, the snapshot holding through a mid-frame input change, and the restart of the lamp test after a reset in the middle of a frame.

// File: rtl/led_scan_pkg.sv
`timescale 1ns/1ps
package led_scan_pkg;
  localparam int NPORT      = 5;
  localparam int BAR_W      = 8;
  localparam int FRAME_BITS = 16;
  localparam int LANES      = 3;

  // slot positions inside each lane (slot 0 leaves first)
  localparam int L0_PART   = 0;
  localparam int L0_JAB    = NPORT;
  localparam int L0_GPART  = 2 * NPORT;
  localparam int L0_RAMF   = 2 * NPORT + 1;
  localparam int L0_GCOL10 = 2 * NPORT + 2;
  localparam int L0_GC100  = 2 * NPORT + 3;
  localparam int L1_ACT    = 0;
  localparam int L1_UTIL   = FRAME_BITS - BAR_W;
  localparam int L2_UTIL   = 0;
  localparam int L2_COLL   = FRAME_BITS - BAR_W;

  typedef logic [FRAME_BITS-1:0] lane_t;
  typedef lane_t [LANES-1:0]     frame_t;

  typedef enum logic [1:0] {SHOW_ALL_ON, SHOW_ALL_OFF, SHOW_LIVE} show_e;
  typedef enum logic [2:0] {PH_ON_A, PH_OFF_A, PH_ON_B, PH_OFF_B, PH_LIVE} phase_e;

  typedef struct packed {
    logic [NPORT-1:0] part;
    logic [NPORT-1:0] jab;
    logic [NPORT-1:0] act;
    logic             gpart;
    logic             ramf;
    logic             gcol10;
    logic             gcol100;
    logic [BAR_W-1:0] util10;
    logic [BAR_W-1:0] util100;
    logic [BAR_W-1:0] coll10;
    logic [BAR_W-1:0] coll100;
  } status_t;
endpackage

// File: rtl/led_scan_timebase.sv
`timescale 1ns/1ps
module led_scan_timebase
  import led_scan_pkg::*;
#(
  parameter int FRAME_CYC    = 1310000,
  parameter int BLINK_FRAMES = 16,
  parameter int DARK_FRAMES  = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  output logic  tick_o,
  output show_e show_o
);
  localparam int CNT_W  = $clog2(FRAME_CYC);
  localparam int PH_MAX = (BLINK_FRAMES > DARK_FRAMES) ? BLINK_FRAMES : DARK_FRAMES;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic [CNT_W-1:0] cyc_cnt;
  phase_e           phase, phase_nxt;
  logic [PH_W-1:0]  ph_cnt, ph_len;

  assign tick_o = (cyc_cnt == CNT_W'(FRAME_CYC - 1));
  assign ph_len = (phase == PH_OFF_B) ? PH_W'(DARK_FRAMES) : PH_W'(BLINK_FRAMES);

  always_comb begin
    case (phase)
      PH_ON_A:  phase_nxt = PH_OFF_A;
      PH_OFF_A: phase_nxt = PH_ON_B;
      PH_ON_B:  phase_nxt = PH_OFF_B;
      default:  phase_nxt = PH_LIVE;
    endcase
  end

  always_comb begin
    case (phase)
      PH_ON_A, PH_ON_B:   show_o = SHOW_ALL_ON;
      PH_OFF_A, PH_OFF_B: show_o = SHOW_ALL_OFF;
      default:            show_o = SHOW_LIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      phase   <= PH_ON_A;
      ph_cnt  <= '0;
    end else begin
      cyc_cnt <= tick_o ? '0 : cyc_cnt + 1'b1;
      if (tick_o && phase != PH_LIVE) begin
        if (ph_cnt == ph_len - 1'b1) begin
          ph_cnt <= '0;
          phase  <= phase_nxt;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/led_scan_map.sv
`timescale 1ns/1ps
module led_scan_map
  import led_scan_pkg::*;
(
  input  status_t st_i,
  output frame_t  lit_o
);
  always_comb begin
    lit_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      lit_o[0][L0_PART + p] = st_i.part[p];
      lit_o[0][L0_JAB + p]  = st_i.jab[p];
      lit_o[1][L1_ACT + p]  = st_i.act[p];
    end
    lit_o[0][L0_GPART]  = st_i.gpart;
    lit_o[0][L0_RAMF]   = st_i.ramf;
    lit_o[0][L0_GCOL10] = st_i.gcol10;
    lit_o[0][L0_GC100]  = st_i.gcol100;
    for (int s = 0; s < BAR_W; s++) begin
      lit_o[1][L1_UTIL + s] = st_i.util10[s];
      lit_o[2][L2_UTIL + s] = st_i.util100[s];
      // thermometer codes: OR of two bars is the taller bar
      lit_o[2][L2_COLL + s] = st_i.coll10[s] | st_i.coll100[s];
    end
  end
endmodule

// File: rtl/led_scan_shifter.sv
`timescale 1ns/1ps
module led_scan_shifter
  import led_scan_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  frame_t           lit_i,
  output logic             sclk_o,
  output logic [LANES-1:0] line_o,
  output logic             busy_o
);
  localparam int DIV_W = $clog2(DIV);
  localparam int HALF  = DIV / 2;
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic             busy;
  logic [DIV_W-1:0] div_cnt;
  logic [BIT_W-1:0] bit_cnt;
  frame_t           shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!busy) begin
      if (start_i) begin
        busy    <= 1'b1;
        div_cnt <= '0;
        bit_cnt <= '0;
        shreg   <= lit_i;
      end
    end else if (div_cnt == DIV_W'(DIV - 1)) begin
      div_cnt <= '0;
      for (int l = 0; l < LANES; l++)
        shreg[l] <= {1'b0, shreg[l][FRAME_BITS-1:1]};
      if (bit_cnt == BIT_W'(FRAME_BITS - 1)) busy <= 1'b0;
      else bit_cnt <= bit_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign busy_o = busy;
  assign sclk_o = busy && (div_cnt >= DIV_W'(HALF));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign line_o[l] = busy ? ~shreg[l][0] : 1'b1;
  end
endmodule

// File: rtl/led_status_scanner.sv
`timescale 1ns/1ps
module led_status_scanner
  import led_scan_pkg::*;
#(
  parameter int FRAME_CYC    = 1310000,
  parameter int BLINK_FRAMES = 16,
  parameter int DARK_FRAMES  = 8,
  parameter int SCLK_DIV     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] port_part_i,
  input  logic [NPORT-1:0] port_jab_i,
  input  logic [NPORT-1:0] port_act_i,
  input  logic             glob_part_i,
  input  logic             ram_fail_i,
  input  logic             glob_col10_i,
  input  logic             glob_col100_i,
  input  logic [BAR_W-1:0] util10_bar_i,
  input  logic [BAR_W-1:0] util100_bar_i,
  input  logic [BAR_W-1:0] coll10_bar_i,
  input  logic [BAR_W-1:0] coll100_bar_i,
  output logic             led_sclk_o,
  output logic [LANES-1:0] led_data_o
);
  status_t st;
  frame_t  live_lit, load_lit;
  show_e   show;
  logic    frame_tick;
  logic    shift_busy;

  assign st = '{part: port_part_i, jab: port_jab_i, act: port_act_i,
                gpart: glob_part_i, ramf: ram_fail_i,
                gcol10: glob_col10_i, gcol100: glob_col100_i,
                util10: util10_bar_i, util100: util100_bar_i,
                coll10: coll10_bar_i, coll100: coll100_bar_i};

  led_scan_timebase #(
    .FRAME_CYC(FRAME_CYC), .BLINK_FRAMES(BLINK_FRAMES), .DARK_FRAMES(DARK_FRAMES)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .tick_o(frame_tick), .show_o(show)
  );

  led_scan_map u_map (.st_i(st), .lit_o(live_lit));

  always_comb begin
    case (show)
      SHOW_ALL_ON:  load_lit = '1;
      SHOW_ALL_OFF: load_lit = '0;
      default:      load_lit = live_lit;
    endcase
  end

  led_scan_shifter #(.DIV(SCLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(frame_tick), .lit_i(load_lit),
    .sclk_o(led_sclk_o), .line_o(led_data_o), .busy_o(shift_busy)
  );
endmodule

// File: rtl/led_scan_checker.sv
`timescale 1ns/1ps
module led_scan_checker
  import led_scan_pkg::*;
#(
  parameter int DIV = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic [LANES-1:0] data,
  input logic             busy,
  input logic             tick
);
  localparam int GAP_W = $clog2(DIV) + 1;

  logic             sclk_q, rise;
  logic [5:0]       rise_cnt;
  logic [GAP_W-1:0] gap;

  assign rise = sclk && !sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
      gap      <= '0;
    end else begin
      sclk_q <= sclk;
      if (!busy) rise_cnt <= '0;
      else if (rise) rise_cnt <= rise_cnt + 1'b1;
      if (rise) gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
    end
  end

  AST_SIXTEEN_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rise_cnt == 6'(FRAME_BITS)); // R1
  AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && rise_cnt != 0) |-> gap == GAP_W'(DIV - 1)); // R2
  AST_STEADY_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(data)); // R2
  AST_TICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !busy); // R3
endmodule

bind led_status_scanner led_scan_checker #(.DIV(SCLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(led_sclk_o), .data(led_data_o),
  .busy(shift_busy), .tick(frame_tick)
);

// File: tb/led_status_scanner_test.sv
`timescale 1ns/1ps
module led_status_scanner_test;
  import led_scan_pkg::*;

  localparam int CLK_PERIOD = 40;
  localparam int FRAME_CYC  = 400;
  localparam int BLINK      = 2;
  localparam int DARK       = 1;
  localparam int DIV        = 10;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [4:0] part, jab, act;
    logic       gpart, ramf, gc10, gc100;
    logic [7:0] u10, u100, c10, c100;
  } stim_t;

  localparam stim_t VEC [NVEC] = '{
    '{5'b00000, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{5'b10101, 5'b01010, 5'b11111, 1'b1, 1'b0, 1'b1, 1'b0, 8'h07, 8'hFF, 8'h01, 8'h0F},
    '{5'b00001, 5'b10000, 5'b00100, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F, 8'h01, 8'h3F, 8'h03},
    '{5'b11111, 5'b11111, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    '{5'b11000, 5'b00011, 5'b10001, 1'b0, 1'b0, 1'b1, 1'b1, 8'h7F, 8'h1F, 8'h00, 8'h7F},
    '{5'b00110, 5'b01100, 5'b01010, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 8'h3F, 8'hFF, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] part, jab, act;
  logic gpart, ramf, gc10, gc100;
  logic [7:0] u10, u100, c10, c100;
  logic led_sclk_o;
  logic [2:0] led_data_o;

  int checks = 0;
  int fails = 0;
  time prev_first = 0;
  bit have_prev = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  led_status_scanner #(
    .FRAME_CYC(FRAME_CYC), .BLINK_FRAMES(BLINK), .DARK_FRAMES(DARK), .SCLK_DIV(DIV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .port_part_i(part), .port_jab_i(jab), .port_act_i(act),
    .glob_part_i(gpart), .ram_fail_i(ramf), .glob_col10_i(gc10), .glob_col100_i(gc100),
    .util10_bar_i(u10), .util100_bar_i(u100), .coll10_bar_i(c10), .coll100_bar_i(c100),
    .led_sclk_o(led_sclk_o), .led_data_o(led_data_o)
  );

  task automatic apply(input stim_t s);
    part = s.part; jab = s.jab; act = s.act; gpart = s.gpart; ramf = s.ramf;
    gc10 = s.gc10; gc100 = s.gc100; u10 = s.u10; u100 = s.u100; c10 = s.c10; c100 = s.c100;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // line levels expected per lane: active low, slot map from R4/R5/R6
  function automatic lane_t line_exp(input int l, input stim_t s);
    lane_t lit = '0;
    if (l == 0) begin
      lit[4:0] = s.part; lit[9:5] = s.jab;
      lit[10] = s.gpart; lit[11] = s.ramf; lit[12] = s.gc10; lit[13] = s.gc100;
    end else if (l == 1) begin
      lit[4:0] = s.act; lit[15:8] = s.u10;
    end else begin
      lit[7:0] = s.u100; lit[15:8] = s.c10 | s.c100;
    end
    return ~lit;
  endfunction

  function automatic bit lamp_on(input int k);
    return (k < BLINK) || (k >= 2 * BLINK && k < 3 * BLINK);
  endfunction

  // receive one frame as an external shift register would
  task automatic capture(input int swap_at, input stim_t swap_s, output frame_t got);
    time t0 = 0, t1 = 0;
    bit bad = 1'b0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      @(posedge led_sclk_o); #1;
      if (i == 0) t0 = $time;
      t1 = $time;
      for (int l = 0; l < LANES; l++) got[l][i] = led_data_o[l];
      if (i == swap_at) apply(swap_s);
    end
    check("R2 edge spacing", 32'(t1 - t0), 32'((FRAME_BITS - 1) * DIV * CLK_PERIOD));
    if (have_prev) check("R3 frame spacing", 32'(t0 - prev_first), 32'(FRAME_CYC * CLK_PERIOD));
    prev_first = t0;
    have_prev = 1'b1;
    repeat (8) @(negedge clk);
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (led_sclk_o !== 1'b0 || led_data_o !== 3'b111) bad = 1'b1;
    end
    check("R1 R7 quiet after frame", 32'(bad), 32'd0);
  endtask

  task automatic check_frame(input string req, input frame_t got, input stim_t s);
    check({req, " lane0 R4"}, 32'(got[0]), 32'(line_exp(0, s)));
    check({req, " lane1 R5"}, 32'(got[1]), 32'(line_exp(1, s)));
    check({req, " lane2 R6"}, 32'(got[2]), 32'(line_exp(2, s)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    frame_t got;
    apply(VEC[1]);
    repeat (4) @(negedge clk);
    check("R10 reset sclk", 32'(led_sclk_o), 32'd0);
    check("R10 reset lines", 32'(led_data_o), 32'h7);
    rst_n = 1'b1;

    // lamp test, live inputs must not leak in
    for (int k = 0; k < 3 * BLINK + DARK; k++) begin
      capture(-1, VEC[0], got);
      for (int l = 0; l < LANES; l++)
        check("R9 lamp test", 32'(got[l]), lamp_on(k) ? 32'h0 : 32'hFFFF);
    end

    // live frames walked from the vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      capture(-1, VEC[0], got);
      check_frame("live", got, VEC[i]);
    end

    // R8: mid-frame change held off until the next frame
    apply(VEC[1]);
    capture(3, VEC[3], got);
    check_frame("R8 snapshot", got, VEC[1]);
    capture(-1, VEC[0], got);
    check_frame("R8 next frame", got, VEC[3]);

    // R10: reset in the middle of a frame restarts the lamp test
    repeat (4) @(posedge led_sclk_o);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 mid-frame reset sclk", 32'(led_sclk_o), 32'd0);
    check("R10 mid-frame reset lines", 32'(led_data_o), 32'h7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    have_prev = 1'b0;
    capture(-1, VEC[0], got);
    for (int l = 0; l < LANES; l++)
      check("R9 R10 lamp restart", 32'(got[l]), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule